// File: doc/BRIEF.md
# I2C Block-Access Configuration Register Slave

This block is a standard-mode I2C slave that holds a small bank of 8-bit configuration registers and presents all of them in parallel to the surrounding logic. A typical user is a clock generator that takes its divider and enable settings from these registers. The host reaches the bank only through whole-block transfers. There is no register pointer. A write always begins filling at register 0, and a read always returns a byte count followed by the registers from register 0 upward.

In a write, the host sends the device address with R/W = 0. It then sends two dummy bytes, a command code and a byte count. The slave acknowledges both and discards both. Every byte after that is stored at the next register index. The host may stop after any complete byte, and registers it did not reach keep their values. In a read, the slave acknowledges the address with R/W = 1 and sends the register count. It then sends the registers until the host answers a byte with NACK.

SCL and SDA are sampled through two-flop synchronisers into the system clock. That clock must run at least ten times faster than SCL. SDA is driven as an open-drain enable: when the enable is high, the pad pulls the line low.

Top module: `i2c_blk_cfg_slave`

## Requirements
- R1: After reset, `regs_o` equals `REG_DEFAULT` and `sda_oe_o` is low. Register i sits at bits `[8i+7:8i]` of `regs_o` and of `REG_DEFAULT`.
- R2: The slave acknowledges an address byte whose upper seven bits equal `DEV_ADDR` (default 0x69, so the bytes 0xD2 and 0xD3). Bit 0 is R/W, with 1 meaning read. For any other address it does not acknowledge, never drives SDA, and ignores the bus until the next start.
- R3: In a write, the two bytes after the address are acknowledged and change no register.
- R4: Each byte after those two is acknowledged and stored, the first at register 0 and each later one at the next index. All bytes are MSB first.
- R5: If a stop ends a write early, only the registers whose bytes arrived are updated. The others keep their previous values.
- R6: A write data byte that arrives after register `N_REGS-1` is not acknowledged and is not stored.
- R7: In a read, after the address is acknowledged, the slave sends the byte count `N_REGS` (0x06 by default). It then sends register 0, 1, and so on, MSB first.
- R8: When the host answers a read byte with NACK, the slave releases SDA and drives nothing more until the next start. Any byte the host clocks out after that reads 0xFF.
- R9: A repeated start, with or without a stop before it, restarts address decoding. A read can follow a write without a stop between them.
- R10: `sda_oe_o` changes only while SCL is low, apart from the release that follows a start or a stop.
- R11: Register contents change only when a data byte is accepted under R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 10x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| regs_o | output | N_REGS*8 | All configuration registers, register i at [8i+7:8i] |

## Verification
The bench builds the block with `N_REGS` = 6 and address 0x69. It uses a distinct, non-zero default for every register, which makes the reset value observable. It also lets a partial write, a discarded dummy byte or an ignored transfer show up as a mismatch in a specific register. SCL runs at 20 system clocks per bit. That leaves room for the synchroniser delay and still keeps every acknowledge and data edge within a few clocks of an SCL fall. With six registers, both the seventh data byte in a write and the read past the last register can be reached.

// File: rtl/i2c_blk_cfg_pkg.sv
package i2c_blk_cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } ph_e;
endpackage

// File: rtl/i2c_blk_cfg_sync.sv
module i2c_blk_cfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_blk_cfg_regs.sv
module i2c_blk_cfg_regs #(
  parameter int unsigned N_REGS = 6,
  parameter int unsigned IDX_W  = 3,
  parameter logic [N_REGS*8-1:0] REG_DEFAULT = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  output logic [N_REGS-1:0][7:0] regs_o
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= REG_DEFAULT[i*8 +: 8];
      else if (wr_en_i && wr_idx_i == IDX_W'(i))     q <= wr_data_i;
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/i2c_blk_cfg_fsm.sv
module i2c_blk_cfg_fsm
  import i2c_blk_cfg_pkg::*;
#(
  parameter int unsigned N_REGS   = 6,
  parameter int unsigned IDX_W    = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sda_i,
  input  logic                   scl_rise_i,
  input  logic                   scl_fall_i,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [N_REGS-1:0][7:0] regs_i,
  output logic                   sda_oe_o,
  output logic                   wr_en_o,
  output logic [IDX_W-1:0]       wr_idx_o,
  output logic [7:0]             wr_data_o
);
  st_e              st_q;
  ph_e              ph_q;
  logic [3:0]       bit_cnt_q;
  logic [2:0]       tx_cnt_q;
  logic [7:0]       shreg_q;
  logic             rd_q;
  logic             mst_nack_q;
  logic [IDX_W-1:0] data_idx_q;
  logic [IDX_W-1:0] tx_idx_q;
  logic [7:0]       tx_byte;

  // byte count first, then registers, then idle-high filler
  always_comb begin
    if (tx_idx_q == '0)                     tx_byte = 8'(N_REGS);
    else if (tx_idx_q <= IDX_W'(N_REGS))    tx_byte = regs_i[tx_idx_q - IDX_W'(1)];
    else                                    tx_byte = 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_ADDR;
      bit_cnt_q  <= '0;
      tx_cnt_q   <= '0;
      shreg_q    <= '0;
      rd_q       <= 1'b0;
      mst_nack_q <= 1'b0;
      data_idx_q <= '0;
      tx_idx_q   <= '0;
      sda_oe_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st_q      <= ST_RX;
        ph_q      <= PH_ADDR;
        bit_cnt_q <= '0;
        rd_q      <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              unique case (ph_q)
                PH_ADDR: begin
                  if (shreg_q[7:1] == DEV_ADDR) begin
                    st_q     <= ST_RX_ACK;
                    sda_oe_o <= 1'b1;
                    rd_q     <= shreg_q[0];
                    ph_q     <= PH_CMD;
                    tx_idx_q <= '0;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                PH_CMD: begin
                  st_q     <= ST_RX_ACK;
                  sda_oe_o <= 1'b1;
                  ph_q     <= PH_CNT;
                end
                PH_CNT: begin
                  st_q       <= ST_RX_ACK;
                  sda_oe_o   <= 1'b1;
                  ph_q       <= PH_DATA;
                  data_idx_q <= '0;
                end
                PH_DATA: begin
                  if (data_idx_q < IDX_W'(N_REGS)) begin
                    st_q       <= ST_RX_ACK;
                    sda_oe_o   <= 1'b1;
                    wr_en_o    <= 1'b1;
                    wr_idx_o   <= data_idx_q;
                    wr_data_o  <= shreg_q;
                    data_idx_q <= data_idx_q + IDX_W'(1);
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                default: st_q <= ST_IDLE;
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              if (rd_q) begin
                st_q     <= ST_TX;
                tx_cnt_q <= '0;
                shreg_q  <= tx_byte;
                sda_oe_o <= ~tx_byte[7];
                tx_idx_q <= tx_idx_q + IDX_W'(1);
              end else begin
                st_q     <= ST_RX;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (tx_cnt_q == 3'd7) begin
                st_q     <= ST_TX_ACK;
                sda_oe_o <= 1'b0;
              end else begin
                shreg_q  <= {shreg_q[6:0], 1'b1};
                sda_oe_o <= ~shreg_q[6];
                tx_cnt_q <= tx_cnt_q + 3'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) mst_nack_q <= sda_i;
            if (scl_fall_i) begin
              if (mst_nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                st_q     <= ST_TX;
                tx_cnt_q <= '0;
                shreg_q  <= tx_byte;
                sda_oe_o <= ~tx_byte[7];
                if (tx_idx_q != IDX_W'(N_REGS + 1)) tx_idx_q <= tx_idx_q + IDX_W'(1);
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_blk_cfg_slave.sv
module i2c_blk_cfg_slave #(
  parameter int unsigned N_REGS      = 6,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [N_REGS*8-1:0] REG_DEFAULT = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  output logic [N_REGS*8-1:0] regs_o
);
  localparam int unsigned IDX_W = $clog2(N_REGS + 2);

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [N_REGS-1:0][7:0] regs_w;

  i2c_blk_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_blk_cfg_fsm #(.N_REGS(N_REGS), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_w), .stop_i(stop_w), .regs_i(regs_w),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  i2c_blk_cfg_regs #(.N_REGS(N_REGS), .IDX_W(IDX_W), .REG_DEFAULT(REG_DEFAULT)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .regs_o(regs_w)
  );

  assign regs_o = regs_w;
endmodule

// File: rtl/i2c_blk_cfg_slave_chk.sv
module i2c_blk_cfg_slave_chk #(
  parameter int unsigned N_REGS = 6,
  parameter int unsigned IDX_W  = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scl_s_i,
  input logic                start_i,
  input logic                stop_i,
  input logic                sda_oe_i,
  input logic                wr_en_i,
  input logic [IDX_W-1:0]    wr_idx_i,
  input logic [N_REGS*8-1:0] regs_i
);
  p_release_on_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  p_release_on_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_i) && !$past(start_i) && !$past(stop_i)) |-> !scl_s_i);

  p_wr_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i < IDX_W'(N_REGS)));

  p_wr_scl_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !scl_s_i);

  p_regs_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_i));
endmodule

bind i2c_blk_cfg_slave i2c_blk_cfg_slave_chk #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .start_i(start_w), .stop_i(stop_w),
  .sda_oe_i(sda_oe_o), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .regs_i(regs_o)
);

// File: tb/i2c_blk_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_blk_cfg_slave_tb_top;
  localparam int N = 6;
  localparam logic [N*8-1:0] DEF = 48'h11C37E813C5A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [N*8-1:0] regs;
  logic [N*8-1:0] model;
  int errs = 0;
  int checks = 0;
  int oe_cnt = 0;
  int viol = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_blk_cfg_slave #(.N_REGS(N), .DEV_ADDR(7'h69), .REG_DEFAULT(DEF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  always @(negedge clk) begin
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    if (rst_n && sda_oe != oe_prev && scl) viol <= viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic hq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; hq(1);
    scl = 1'b1;   hq(1);
    sda_m = 1'b0; hq(1);
    scl = 1'b0;   hq(1);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; hq(1);
    scl = 1'b1;   hq(1);
    sda_m = 1'b1; hq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq(1);
      scl = 1'b1;   hq(1);
      scl = 1'b0;
    end
    sda_m = 1'b1; hq(1);
    scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    ack = ~sda_bus;
    repeat (Q/2) @(negedge clk);
    scl = 1'b0; hq(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(1);
      scl = 1'b1;
      repeat (Q/2) @(negedge clk);
      b[i] = sda_bus;
      repeat (Q/2) @(negedge clk);
      scl = 1'b0;
    end
    hq(1);
    sda_m = ~ack;
    scl = 1'b1; hq(1);
    scl = 1'b0; hq(1);
    sda_m = 1'b1;
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < N; i++)
      chk(64'(regs[i*8 +: 8]), 64'(model[i*8 +: 8]), $sformatf("%s reg%0d", tag, i));
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 37);
  endfunction

  task automatic t_reset;
    chk(64'(regs), 64'(DEF), "R1 regs default");
    chk(64'(sda_oe), 64'd0, "R1 oe idle");
  endtask

  task automatic t_full_write;
    logic a;
    i2c_start;
    send_byte(8'hD2, a); chk(64'(a), 64'd1, "R2 write addr ack");
    send_byte(8'hA5, a); chk(64'(a), 64'd1, "R3 cmd ack");
    send_byte(8'h5C, a); chk(64'(a), 64'd1, "R3 count ack");
    for (int i = 0; i < N; i++) begin
      send_byte(pat(3, i), a);
      chk(64'(a), 64'd1, $sformatf("R4 data%0d ack", i));
      model[i*8 +: 8] = pat(3, i);
    end
    i2c_stop;
    check_regs("R4");
  endtask

  task automatic t_dummy_only;
    logic a;
    i2c_start;
    send_byte(8'hD2, a);
    send_byte(8'hFF, a);
    send_byte(8'h00, a);
    i2c_stop;
    check_regs("R3/R11");
  endtask

  task automatic t_partial;
    logic a;
    i2c_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    for (int i = 0; i < 2; i++) begin
      send_byte(pat(91, i), a);
      model[i*8 +: 8] = pat(91, i);
    end
    i2c_stop;
    check_regs("R5");
  endtask

  task automatic t_overflow;
    logic a;
    i2c_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h07, a);
    for (int i = 0; i < N; i++) begin
      send_byte(pat(200, i), a);
      model[i*8 +: 8] = pat(200, i);
    end
    send_byte(8'hEE, a);
    chk(64'(a), 64'd0, "R6 extra byte nack");
    i2c_stop;
    check_regs("R6");
  endtask

  task automatic t_read;
    logic a;
    logic [7:0] b;
    int snap;
    i2c_start;
    send_byte(8'hD3, a); chk(64'(a), 64'd1, "R7 read addr ack");
    recv_byte(b, 1'b1);  chk(64'(b), 64'(N), "R7 byte count");
    for (int i = 0; i < N; i++) begin
      recv_byte(b, i != N - 1);
      chk(64'(b), 64'(model[i*8 +: 8]), $sformatf("R7 read reg%0d", i));
    end
    snap = oe_cnt;
    hq(4);
    chk(64'(oe_cnt - snap), 64'd0, "R8 released after nack");
    i2c_stop;
  endtask

  task automatic t_read_early_nack;
    logic a;
    logic [7:0] b;
    int snap;
    i2c_start;
    send_byte(8'hD3, a);
    recv_byte(b, 1'b0);
    chk(64'(b), 64'(N), "R7 count before nack");
    snap = oe_cnt;
    recv_byte(b, 1'b0);
    chk(64'(b), 64'hFF, "R8 bus idle after nack");
    chk(64'(oe_cnt - snap), 64'd0, "R8 no drive after nack");
    i2c_stop;
  endtask

  task automatic t_bad_addr;
    logic a;
    int snap;
    i2c_start;
    send_byte(8'hA4, a); chk(64'(a), 64'd0, "R2 foreign addr nack");
    snap = oe_cnt;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    send_byte(8'h3F, a);
    chk(64'(oe_cnt - snap), 64'd0, "R2 ignored until start");
    i2c_stop;
    check_regs("R2/R11");
  endtask

  task automatic t_rstart;
    logic a;
    logic [7:0] b;
    i2c_start;
    send_byte(8'hA4, a);
    i2c_start;
    send_byte(8'hD2, a); chk(64'(a), 64'd1, "R9 addr after rstart");
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    send_byte(8'h77, a); chk(64'(a), 64'd1, "R9 data ack");
    model[7:0] = 8'h77;
    i2c_start;
    send_byte(8'hD3, a); chk(64'(a), 64'd1, "R9 read after write");
    recv_byte(b, 1'b1);  chk(64'(b), 64'(N), "R9 count");
    recv_byte(b, 1'b0);  chk(64'(b), 64'h77, "R9 reg0 readback");
    i2c_stop;
    check_regs("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    model = DEF;
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_full_write;
    t_dummy_only;
    t_partial;
    t_overflow;
    t_read;
    t_read_early_nack;
    t_bad_addr;
    t_rstart;
    chk(64'(viol), 64'd0, "R10 oe changes only with scl low");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule